// File: doc/BRIEF.md
# Float-to-Logarithm Piecewise Converter

This block turns an IEEE-754 single-precision number into a signed fixed-point base-2 logarithm, for a datapath that adds and subtracts in floating point but multiplies, divides and takes roots in the log domain. The number's magnitude is 2^e × (1+m). The unbiased exponent e becomes the integer part of the result. The fractional part, log2(1+m), comes from a straight-line fit a·m + b. The slope and offset of that line are chosen by the region of [0,1) that m falls in.

The mantissa range is cut into 15 regions. The first 14 each cover one sixteenth of the range, and the last region covers the top eighth. The coefficient pairs are computed at elaboration as the chord of log2(1+m) across each region, so no table is written out by hand. The input sign leaves the block as a separate flag. A zero input and an exponent-all-ones input (infinity or NaN) are flagged, and each is given a fixed output code.

The converter is a two-stage pipeline and accepts a new value on every cycle. Stage one unpacks the fields, selects the region and reads the coefficients. Stage two evaluates the line, joins the integer and fractional parts, saturates, and registers the outputs.

Top module: `flt2log_conv`

## Requirements
- R1: `out_vld` is high exactly two clock cycles after `in_vld` was high, and on that cycle the outputs belong to that input; back-to-back inputs give back-to-back results.
- R2: `out_log` is two's complement with 24 fractional bits; an input whose mantissa field is zero and whose exponent field is E (1..254) gives exactly (E-127)·2^24.
- R3: for every input with exponent field 1..254, 2^(out_log/2^24) lies within 0.41% of the input's magnitude.
- R4: `out_sgn` equals bit 31 of the input that produced the result.
- R5: an input with bits 30:0 all zero (either sign) gives `out_zero`=1 and `out_log`=0x80000000, the most negative code.
- R6: an input with exponent field 255 (bits 30:23 all ones) gives `out_spec`=1 and `out_log`=0x7FFFFFFF; a finite input gives `out_spec`=0.
- R7: while `out_vld` is low, `out_log` and the flags keep their last values whatever `in_flt` does.
- R8: while `rst_n` is low and right after it is released, `out_vld`, `out_log`, `out_sgn`, `out_zero` and `out_spec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Marks `in_flt` as a value to convert |
| in_flt | input | 32 | Single-precision input |
| out_vld | output | 1 | Result valid, two cycles after `in_vld` |
| out_log | output | 32 | Signed log2 of the magnitude, 8 integer and 24 fractional bits |
| out_sgn | output | 1 | Sign bit of the input |
| out_zero | output | 1 | Input was zero |
| out_spec | output | 1 | Input was infinity or NaN |

## Verification
The bench builds the converter with its default parameters: 8 integer bits, 24 fractional bits, 15 regions and a 4-bit region selector. These values put every exponent from -126 to +127 within reach of the exact power-of-two vectors. They let the random sweep hit all 15 regions, including the double-width top region where the chord error is largest. They also reach both ends of the output range, the zero code and the saturated special code. Every result is compared in real arithmetic against the true logarithm, so the coefficient values themselves are never copied into the bench.

// File: rtl/flt2log_pkg.sv
package flt2log_pkg;

  localparam int unsigned MANT_W   = 23;
  localparam int unsigned EXP_W    = 8;
  localparam int unsigned EXP_BIAS = 127;
  localparam int unsigned EXP_SW   = EXP_W + 2;

  function automatic real lg2(input real x);
    return $ln(x) / $ln(2.0);
  endfunction

  // lower edge of region k, in units of the mantissa range
  function automatic real seg_lo(input int k, input int sel_w);
    return real'(k) / real'(1 << sel_w);
  endfunction

  // upper edge; the last region stretches to 1.0
  function automatic real seg_hi(input int k, input int sel_w, input int n_seg);
    if (k == n_seg - 1) return 1.0;
    return real'(k + 1) / real'(1 << sel_w);
  endfunction

  function automatic real chord_slope(input int k, input int sel_w, input int n_seg);
    real lo;
    real hi;
    lo = seg_lo(k, sel_w);
    hi = seg_hi(k, sel_w, n_seg);
    return (lg2(1.0 + hi) - lg2(1.0 + lo)) / (hi - lo);
  endfunction

  // slope scaled by 2^(frac_w-1), rounded to nearest
  function automatic int slope_code(input int k, input int sel_w, input int n_seg, input int frac_w);
    return $rtoi(chord_slope(k, sel_w, n_seg) * (2.0 ** (frac_w - 1)) + 0.5);
  endfunction

  // offset scaled by 2^frac_w, rounded to nearest
  function automatic int offset_code(input int k, input int sel_w, input int n_seg, input int frac_w);
    real lo;
    lo = seg_lo(k, sel_w);
    return $rtoi((lg2(1.0 + lo) - chord_slope(k, sel_w, n_seg) * lo) * (2.0 ** frac_w) + 0.5);
  endfunction

endpackage

// File: rtl/flt2log_seg_sel.sv
module flt2log_seg_sel #(
  parameter int SEL_W = 4,
  parameter int N_SEG = 15,
  localparam int IDX_W = $clog2(N_SEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] top_bits,
  output logic [IDX_W-1:0] seg_idx
);

  // one comparator per boundary; boundary k sits at k/2^SEL_W
  logic [N_SEG-2:0] past_edge;

  for (genvar k = 1; k < N_SEG; k++) begin : g_edge
    assign past_edge[k-1] = (top_bits >= SEL_W'(k));
  end

  assign seg_idx = IDX_W'($countones(past_edge));

  p_seg_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seg_idx <= IDX_W'(N_SEG - 1));

endmodule

// File: rtl/flt2log_coef_rom.sv
module flt2log_coef_rom #(
  parameter int SEL_W  = 4,
  parameter int N_SEG  = 15,
  parameter int FRAC_W = 24,
  localparam int IDX_W = $clog2(N_SEG)
) (
  input  logic [IDX_W-1:0]  seg_idx,
  output logic [FRAC_W-1:0] slope,
  output logic [FRAC_W-1:0] offset
);

  logic [FRAC_W-1:0] slope_tab  [N_SEG];
  logic [FRAC_W-1:0] offset_tab [N_SEG];

  for (genvar k = 0; k < N_SEG; k++) begin : g_ent
    localparam logic [FRAC_W-1:0] SK = FRAC_W'(flt2log_pkg::slope_code(k, SEL_W, N_SEG, FRAC_W));
    localparam logic [FRAC_W-1:0] OK = FRAC_W'(flt2log_pkg::offset_code(k, SEL_W, N_SEG, FRAC_W));
    assign slope_tab[k]  = SK;
    assign offset_tab[k] = OK;
  end

  assign slope  = slope_tab[seg_idx];
  assign offset = offset_tab[seg_idx];

endmodule

// File: rtl/flt2log_pack.sv
module flt2log_pack #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 24,
  localparam int MANT_W = flt2log_pkg::MANT_W,
  localparam int EXP_SW = flt2log_pkg::EXP_SW,
  localparam int LOG_W  = INT_W + FRAC_W,
  localparam int PROD_W = FRAC_W + MANT_W,
  localparam int WIDE_W = LOG_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s1_vld,
  input  logic                     s1_sgn,
  input  logic                     s1_zero,
  input  logic                     s1_spec,
  input  logic signed [EXP_SW-1:0] s1_exp,
  input  logic [MANT_W-1:0]        s1_mant,
  input  logic [FRAC_W-1:0]        s1_slope,
  input  logic [FRAC_W-1:0]        s1_offset,
  output logic                     out_vld,
  output logic [LOG_W-1:0]         out_log,
  output logic                     out_sgn,
  output logic                     out_zero,
  output logic                     out_spec
);

  localparam logic signed [WIDE_W-1:0] MAX_POS = WIDE_W'({1'b0, {(LOG_W-1){1'b1}}});
  localparam logic signed [WIDE_W-1:0] MIN_NEG = -MAX_POS - WIDE_W'(1);
  localparam logic [LOG_W-1:0] CODE_ZERO = {1'b1, {(LOG_W-1){1'b0}}};
  localparam logic [LOG_W-1:0] CODE_SPEC = {1'b0, {(LOG_W-1){1'b1}}};

  // a*m + b with a in Q1.(FRAC_W-1), m in Q0.MANT_W, b in Q0.FRAC_W
  function automatic logic [FRAC_W:0] line_eval(input logic [FRAC_W-1:0] a,
                                                input logic [MANT_W-1:0] m,
                                                input logic [FRAC_W-1:0] b);
    logic [PROD_W:0] acc;
    acc = (PROD_W+1)'(a) * (PROD_W+1)'(m) + ((PROD_W+1)'(b) << (MANT_W - 1));
    return acc[MANT_W-1 +: FRAC_W+1];
  endfunction

  // integer part from the exponent plus the fraction, clamped to the code range
  function automatic logic [LOG_W-1:0] join_sat(input logic signed [EXP_SW-1:0] e,
                                                input logic [FRAC_W:0] f);
    logic signed [WIDE_W-1:0] wide;
    wide = (WIDE_W'(e) <<< FRAC_W) + $signed(WIDE_W'(f));
    if (wide > MAX_POS) return CODE_SPEC;
    if (wide < MIN_NEG) return CODE_ZERO;
    return wide[LOG_W-1:0];
  endfunction

  logic [FRAC_W:0]  frac_val;
  logic [LOG_W-1:0] log_next;

  assign frac_val = line_eval(s1_slope, s1_mant, s1_offset);

  always_comb begin
    if (s1_spec)      log_next = CODE_SPEC;
    else if (s1_zero) log_next = CODE_ZERO;
    else              log_next = join_sat(s1_exp, frac_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_log  <= '0;
      out_sgn  <= 1'b0;
      out_zero <= 1'b0;
      out_spec <= 1'b0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) begin
        out_log  <= log_next;
        out_sgn  <= s1_sgn;
        out_zero <= s1_zero;
        out_spec <= s1_spec;
      end
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> $stable(out_log) && $stable(out_sgn) && $stable(out_zero) && $stable(out_spec));

endmodule

// File: rtl/flt2log_conv.sv
module flt2log_conv #(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 24,
  parameter int N_SEG  = 15,
  parameter int SEL_W  = 4,
  localparam int LOG_W  = INT_W + FRAC_W,
  localparam int IDX_W  = $clog2(N_SEG),
  localparam int MANT_W = flt2log_pkg::MANT_W,
  localparam int EXP_W  = flt2log_pkg::EXP_W,
  localparam int EXP_SW = flt2log_pkg::EXP_SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [31:0]      in_flt,
  output logic             out_vld,
  output logic [LOG_W-1:0] out_log,
  output logic             out_sgn,
  output logic             out_zero,
  output logic             out_spec
);

  // field extraction
  logic [EXP_W-1:0]  exp_fld;
  logic [MANT_W-1:0] mant_fld;
  logic              is_zero;
  logic              is_spec;
  logic signed [EXP_SW-1:0] exp_unb;

  assign exp_fld  = in_flt[30:23];
  assign mant_fld = in_flt[22:0];
  assign is_zero  = (exp_fld == '0) && (mant_fld == '0);
  assign is_spec  = (exp_fld == '1);
  assign exp_unb  = $signed(EXP_SW'(exp_fld)) - EXP_SW'(flt2log_pkg::EXP_BIAS);

  // region select and coefficient read
  logic [IDX_W-1:0]  seg_idx;
  logic [FRAC_W-1:0] slope_rd;
  logic [FRAC_W-1:0] offset_rd;

  flt2log_seg_sel #(.SEL_W(SEL_W), .N_SEG(N_SEG)) u_seg (
    .clk(clk), .rst_n(rst_n),
    .top_bits(mant_fld[MANT_W-1 -: SEL_W]),
    .seg_idx(seg_idx)
  );

  flt2log_coef_rom #(.SEL_W(SEL_W), .N_SEG(N_SEG), .FRAC_W(FRAC_W)) u_rom (
    .seg_idx(seg_idx), .slope(slope_rd), .offset(offset_rd)
  );

  // stage 1 register
  logic                     s1_vld, s1_sgn, s1_zero, s1_spec;
  logic signed [EXP_SW-1:0] s1_exp;
  logic [MANT_W-1:0]        s1_mant;
  logic [FRAC_W-1:0]        s1_slope, s1_offset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld    <= 1'b0;
      s1_sgn    <= 1'b0;
      s1_zero   <= 1'b0;
      s1_spec   <= 1'b0;
      s1_exp    <= '0;
      s1_mant   <= '0;
      s1_slope  <= '0;
      s1_offset <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_sgn    <= in_flt[31];
        s1_zero   <= is_zero;
        s1_spec   <= is_spec;
        s1_exp    <= exp_unb;
        s1_mant   <= mant_fld;
        s1_slope  <= slope_rd;
        s1_offset <= offset_rd;
      end
    end
  end

  // stage 2: line evaluation, join, output register
  flt2log_pack #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .s1_vld(s1_vld), .s1_sgn(s1_sgn), .s1_zero(s1_zero), .s1_spec(s1_spec),
    .s1_exp(s1_exp), .s1_mant(s1_mant), .s1_slope(s1_slope), .s1_offset(s1_offset),
    .out_vld(out_vld), .out_log(out_log), .out_sgn(out_sgn),
    .out_zero(out_zero), .out_spec(out_spec)
  );

  p_lat_vld_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> ##2 out_vld);
  p_lat_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |-> ##2 !out_vld);
  p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |-> ##2 (out_sgn == $past(in_flt[31], 2)));
  p_zero_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_flt[30:0] == '0) |-> ##2 (out_zero && out_log == {1'b1, {(LOG_W-1){1'b0}}}));
  p_spec_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_flt[30:23] == '1) |-> ##2 (out_spec && out_log == {1'b0, {(LOG_W-1){1'b1}}}));
  p_reset_r8: assert property (@(posedge clk)
    !rst_n |-> !out_vld && out_log == '0);

endmodule

// File: tb/test_flt2log_conv.sv
module test_flt2log_conv;

  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 6;
  // {input float, expected log code}
  localparam logic [63:0] VEC [N_VEC] = '{
    {32'h3F800000, 32'h00000000},   //  1.0  -> 0
    {32'h40000000, 32'h01000000},   //  2.0  -> 1
    {32'h3F000000, 32'hFF000000},   //  0.5  -> -1
    {32'hC0800000, 32'h02000000},   // -4.0  -> 2
    {32'h00800000, 32'h82000000},   //  2^-126
    {32'h7F000000, 32'h7F000000}    //  2^127
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [31:0] in_flt = '0;
  logic out_vld;
  logic [31:0] out_log;
  logic out_sgn, out_zero, out_spec;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flt2log_conv i_flt2log_conv (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_flt(in_flt),
    .out_vld(out_vld), .out_log(out_log), .out_sgn(out_sgn),
    .out_zero(out_zero), .out_spec(out_spec)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample two rising edges later
  task automatic convert(input logic [31:0] x);
    @(negedge clk); in_vld = 1'b1; in_flt = x;
    @(negedge clk); in_vld = 1'b0;
    @(negedge clk);
  endtask

  function automatic real ref_log2(input logic [31:0] x);
    return real'(int'(x[30:23]) - 127) + $ln(1.0 + real'(x[22:0]) / 8388608.0) / $ln(2.0);
  endfunction

  initial begin
    logic [31:0] held;
    // R8 reset state
    repeat (3) @(negedge clk);
    chk(!out_vld && out_log == 0 && !out_sgn && !out_zero && !out_spec, "R8 reset", out_log, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_vld && out_log == 0, "R8 after release", {31'b0, out_vld}, 0);

    // stimulus table streamed back to back: R1, R2, R4
    for (int j = 0; j < N_VEC + 2; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        chk(out_vld, "R1 valid two cycles later", {31'b0, out_vld}, 1);
        chk(out_log == VEC[j-2][31:0], "R2 exact power of two", out_log, VEC[j-2][31:0]);
        chk(out_sgn == VEC[j-2][63], "R4 sign flag", {31'b0, out_sgn}, {31'b0, VEC[j-2][63]});
      end else begin
        chk(!out_vld, "R1 no early valid", {31'b0, out_vld}, 0);
      end
      if (j < N_VEC) begin in_vld = 1'b1; in_flt = VEC[j][63:32]; end
      else           begin in_vld = 1'b0; in_flt = 32'h12345678; end
    end

    // R7 outputs hold while valid is low
    @(negedge clk);
    held = out_log;
    chk(!out_vld, "R1 valid drops", {31'b0, out_vld}, 0);
    for (int k = 0; k < 5; k++) begin
      in_flt = $urandom;
      @(negedge clk);
      chk(!out_vld && out_log == held && out_sgn == 1'b0 && !out_zero && !out_spec,
          "R7 hold", out_log, held);
    end

    // R5 zero inputs of both signs
    convert(32'h00000000);
    chk(out_zero && out_log == 32'h80000000 && !out_sgn, "R5 +0", out_log, 32'h80000000);
    convert(32'h80000000);
    chk(out_zero && out_log == 32'h80000000 && out_sgn, "R5 -0", out_log, 32'h80000000);

    // R6 infinities and NaN
    convert(32'h7F800000);
    chk(out_spec && !out_zero && out_log == 32'h7FFFFFFF, "R6 +inf", out_log, 32'h7FFFFFFF);
    convert(32'hFFC00001);
    chk(out_spec && out_sgn && out_log == 32'h7FFFFFFF, "R6 NaN", out_log, 32'h7FFFFFFF);
    convert(32'h7F7FFFFF);
    chk(!out_spec && !out_zero && out_log[31:24] == 8'h7F, "R6 largest finite", out_log, 32'h7F000000);

    // R3 accuracy: region edges, then random finite values
    for (int k = 0; k < 16; k++) begin
      logic [31:0] x;
      real err;
      x = {1'b0, 8'd127, 4'(k), 19'h7FFFF};
      convert(x);
      err = (2.0 ** ($itor($signed(out_log)) / 16777216.0 - ref_log2(x))) - 1.0;
      chk(err <= 0.0041 && err >= -0.0041, "R3 region edge", out_log, x);
    end
    for (int n = 0; n < 400; n++) begin
      logic [31:0] x;
      real err;
      x = $urandom;
      if (x[30:23] == 8'd0)   x[30:23] = 8'd1;
      if (x[30:23] == 8'd255) x[30:23] = 8'd254;
      convert(x);
      err = (2.0 ** ($itor($signed(out_log)) / 16777216.0 - ref_log2(x))) - 1.0;
      chk(out_vld && !out_spec && !out_zero && err <= 0.0041 && err >= -0.0041,
          "R3 random accuracy", out_log, x);
      chk(out_sgn == x[31], "R4 random sign", {31'b0, out_sgn}, {31'b0, x[31]});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule